// File: doc/BRIEF.md
# Half-Word Static RAM Access Controller

This block sits between a synchronous host and an asynchronous 32-bit static RAM. The host presents one request at a time: an address, a write flag, a two-bit lane mask and write data, qualified by a valid signal and accepted while the controller shows ready. The controller then runs the memory's strobes for a fixed number of clock cycles. It selects the device through an active-low enable and an active-high enable, and it pulses output enable for a read or write enable for a write. It drives only the selected 16-bit halves of the data bus, and only after a turnaround gap, so the memory and the controller never drive the bus at the same time.

Read data is sampled on the last cycle of the read window and returned to the host with a single-cycle valid pulse. Lanes that were not requested return zero. Access length, write pulse length and turnaround gap are parameters counted in controller clocks. The tri-state bus is split into a drive value, a per-lane drive enable and a sampled input, so the pad ring decides how the bus is built.

Top module: `sram_hw_ctrl`

## Requirements
- R1: Out of reset and whenever `req_ready` is high, the pins are idle: `mem_en1_n`=1, `mem_en2`=0, `mem_we_n`=1, `mem_oe_n`=1 and `mem_dq_oe`=00.
- R2: Whenever `mem_we_n` or `mem_oe_n` is low, the device is selected (`mem_en1_n`=0 and `mem_en2`=1). The two strobes are never low together.
- R3: An accepted read holds `mem_oe_n` low and `mem_we_n` high for RD_CYC cycles with `req_ready` low. `rsp_valid` is then high for exactly one cycle, the cycle in which `req_ready` returns.
- R4: Lane mask bit 0 selects data bits 15:0 and drives `mem_lo_n` low. Bit 1 selects bits 31:16 and drives `mem_hi_n` low. Both pins stay high while idle.
- R5: `rsp_rdata` carries the memory content of each selected lane and zero in each unselected lane. Mask 00 returns all zeros.
- R6: An accepted write holds `mem_we_n` low for TURN_CYC+WR_CYC cycles with `mem_oe_n` high, and `req_ready` returns after TURN_CYC+WR_CYC+1 cycles.
- R7: Write data is driven only after `mem_we_n` has been low for TURN_CYC cycles. It is then driven for WR_CYC cycles with `mem_we_n` low and for one further cycle after `mem_we_n` rises, with the device still selected.
- R8: A write drives only the selected lanes. A write with mask 00 drives nothing and leaves the memory unchanged.
- R9: Address, lane enables and write data stay constant for the whole access.
- R10: The controller never drives a lane while `mem_oe_n` is low, so the bus is never driven from both sides.
- R11: A request presented while `req_ready` is low is ignored and does not start an access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Host request strobe |
| req_ready | output | 1 | Controller idle; a request is taken when valid and ready are both high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_lanes | input | 2 | Active-high half-word select: bit 0 = bits 15:0, bit 1 = bits 31:16 |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 32 | Read data, unselected lanes zero |
| mem_addr | output | 17 | Memory address |
| mem_en1_n | output | 1 | Active-low device enable |
| mem_en2 | output | 1 | Active-high device enable |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_lo_n | output | 1 | Active-low enable for bits 15:0 |
| mem_hi_n | output | 1 | Active-low enable for bits 31:16 |
| mem_dq_out | output | 32 | Value driven onto the data bus |
| mem_dq_oe | output | 2 | Per-lane drive enable (bit 0 = bits 15:0) |
| mem_dq_in | input | 32 | Data bus as seen at the pads |

## Verification
The assertions assume that reset is applied before the first access and that every timing parameter is at least one. In particular, the rule that data appears only after write enable has already been low for a cycle depends on a turnaround gap of at least one clock. The assertions make no assumption about the host fields, because the controller latches them at acceptance. The stimulus therefore changes address, mask and data freely, including while the controller is busy, and keeps the parameters at their defaults. The bench's memory model drives the bus only for selected lanes under the read truth table, and it fills floating lanes with a fixed non-zero pattern so that missing lane masking shows up.

// File: rtl/sram_hw_pkg.sv
package sram_hw_pkg;

  // Access sequencer phases; the order is not decoded anywhere
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RD    = 3'd1,
    ST_WGAP  = 3'd2,
    ST_WDATA = 3'd3,
    ST_WHOLD = 3'd4
  } seq_state_t;

endpackage

// File: rtl/sram_hw_seq.sv
module sram_hw_seq
  import sram_hw_pkg::*;
#(
  parameter int RD_CYC   = 2,
  parameter int WR_CYC   = 3,
  parameter int TURN_CYC = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       start_wr,
  output seq_state_t state_q,
  output seq_state_t state_d,
  output logic       last
);

  localparam int MAX_AB = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
  localparam int MAX_C  = (MAX_AB > TURN_CYC) ? MAX_AB : TURN_CYC;
  localparam int CW     = $clog2(MAX_C + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign last = (cnt_q == '0);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = start_wr ? ST_WGAP : ST_RD;
          cnt_d   = start_wr ? CW'(TURN_CYC - 1) : CW'(RD_CYC - 1);
        end
      end
      ST_RD: begin
        if (last) state_d = ST_IDLE;
        else      cnt_d   = cnt_q - 1'b1;
      end
      ST_WGAP: begin
        if (last) begin
          state_d = ST_WDATA;
          cnt_d   = CW'(WR_CYC - 1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_WDATA: begin
        if (last) state_d = ST_WHOLD;
        else      cnt_d   = cnt_q - 1'b1;
      end
      ST_WHOLD: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

endmodule

// File: rtl/sram_hw_pins.sv
module sram_hw_pins
  import sram_hw_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 32,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_state_t        state_d,
  input  logic              load,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [LANES-1:0]  in_lanes,
  input  logic [DATA_W-1:0] in_wdata,
  output logic [LANES-1:0]  lanes_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic              en1_n_q,
  output logic              en2_q,
  output logic              we_n_q,
  output logic              oe_n_q,
  output logic [LANES-1:0]  hw_n_q,
  output logic [LANES-1:0]  dq_oe_q
);

  logic             busy_d, rd_d, wlow_d, drv_d;
  logic [LANES-1:0] lanes_d, hw_n_d, dq_oe_d;

  always_comb begin
    busy_d  = (state_d != ST_IDLE);
    rd_d    = (state_d == ST_RD);
    wlow_d  = (state_d == ST_WGAP) || (state_d == ST_WDATA);
    drv_d   = (state_d == ST_WDATA) || (state_d == ST_WHOLD);
    lanes_d = load ? in_lanes : lanes_q;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign hw_n_d[l]  = !(busy_d && lanes_d[l]);
    assign dq_oe_d[l] = drv_d && lanes_d[l];
  end

  // Request fields: loaded only on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lanes_q <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (load) begin
      lanes_q <= in_lanes;
      addr_q  <= in_addr;
      wdata_q <= in_wdata;
    end
  end

  // Strobes: registered so the pins change only at clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en1_n_q <= 1'b1;
      en2_q   <= 1'b0;
      we_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      hw_n_q  <= '1;
      dq_oe_q <= '0;
    end else begin
      en1_n_q <= !busy_d;
      en2_q   <= busy_d;
      we_n_q  <= !wlow_d;
      oe_n_q  <= !rd_d;
      hw_n_q  <= hw_n_d;
      dq_oe_q <= dq_oe_d;
    end
  end

endmodule

// File: rtl/sram_hw_rcap.sv
module sram_hw_rcap
  import sram_hw_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_state_t        state_q,
  input  logic              last,
  input  logic [LANES-1:0]  lanes_q,
  input  logic [DATA_W-1:0] dq_in,
  output logic              rsp_valid_q,
  output logic [DATA_W-1:0] rdata_q
);

  localparam int LW = DATA_W / LANES;

  logic              cap;
  logic [DATA_W-1:0] rdata_d;

  assign cap = (state_q == ST_RD) && last;

  for (genvar l = 0; l < LANES; l++) begin : g_mask
    assign rdata_d[l*LW +: LW] = lanes_q[l] ? dq_in[l*LW +: LW] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
    end else begin
      rsp_valid_q <= cap;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (cap) begin
      rdata_q <= rdata_d;
    end
  end

endmodule

// File: rtl/sram_hw_ctrl.sv
module sram_hw_ctrl
  import sram_hw_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 32,
  parameter int RD_CYC   = 2,
  parameter int WR_CYC   = 3,
  parameter int TURN_CYC = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_lanes,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_en1_n,
  output logic              mem_en2,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic              mem_lo_n,
  output logic              mem_hi_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic [1:0]        mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int LANES = 2;

  seq_state_t       state_q, state_d;
  logic             last, accept;
  logic [LANES-1:0] lanes_q, hw_n;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;

  sram_hw_seq #(
    .RD_CYC(RD_CYC), .WR_CYC(WR_CYC), .TURN_CYC(TURN_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept), .start_wr(req_write),
    .state_q(state_q), .state_d(state_d), .last(last)
  );

  sram_hw_pins #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)
  ) u_pins (
    .clk(clk), .rst_n(rst_n), .state_d(state_d), .load(accept),
    .in_addr(req_addr), .in_lanes(req_lanes), .in_wdata(req_wdata),
    .lanes_q(lanes_q), .addr_q(mem_addr), .wdata_q(mem_dq_out),
    .en1_n_q(mem_en1_n), .en2_q(mem_en2), .we_n_q(mem_we_n),
    .oe_n_q(mem_oe_n), .hw_n_q(hw_n), .dq_oe_q(mem_dq_oe)
  );

  assign mem_lo_n = hw_n[0];
  assign mem_hi_n = hw_n[1];

  sram_hw_rcap #(
    .DATA_W(DATA_W), .LANES(LANES)
  ) u_rcap (
    .clk(clk), .rst_n(rst_n), .state_q(state_q), .last(last),
    .lanes_q(lanes_q), .dq_in(mem_dq_in),
    .rsp_valid_q(rsp_valid), .rdata_q(rsp_rdata)
  );

endmodule

// File: rtl/sram_hw_ctrl_chk.sv
module sram_hw_ctrl_chk #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_en1_n,
  input logic              mem_en2,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_lo_n,
  input logic              mem_hi_n,
  input logic [DATA_W-1:0] mem_dq_out,
  input logic [1:0]        mem_dq_oe
);

  assert_idle_pins_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_en1_n && !mem_en2 && mem_we_n && mem_oe_n && mem_dq_oe == 2'b00));

  assert_strobe_selected_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n || !mem_oe_n) |-> (!mem_en1_n && mem_en2));

  assert_strobes_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n && !mem_oe_n));

  assert_rsp_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_rsp_after_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(!mem_oe_n) && req_ready));

  assert_lane_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_dq_oe[0] || !mem_lo_n) && (!mem_dq_oe[1] || !mem_hi_n));

  assert_drive_after_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe != 2'b00) |-> (!mem_we_n && $past(!mem_we_n)));

  assert_we_rise_selected_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (!mem_en1_n && mem_en2));

  assert_fields_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && $past(!req_ready)) |->
      ($stable(mem_addr) && $stable(mem_lo_n) && $stable(mem_hi_n) && $stable(mem_dq_out)));

  assert_no_contention_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_dq_oe == 2'b00));

endmodule

bind sram_hw_ctrl sram_hw_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .mem_addr(mem_addr), .mem_en1_n(mem_en1_n), .mem_en2(mem_en2),
  .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_lo_n(mem_lo_n),
  .mem_hi_n(mem_hi_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe)
);

// File: tb/tb_sram_hw_ctrl.sv
module tb_sram_hw_ctrl;

  localparam int AW = 17;
  localparam int DW = 32;
  localparam int RD = 2;
  localparam int WR = 3;
  localparam int TN = 1;
  localparam int WD_LIMIT = 150000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_lanes = 2'b00;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] mem_addr;
  logic          mem_en1_n, mem_en2, mem_we_n, mem_oe_n, mem_lo_n, mem_hi_n;
  logic [DW-1:0] mem_dq_out;
  logic [1:0]    mem_dq_oe;
  logic [DW-1:0] mem_dq_in = 32'hA5A5_A5A5;

  always #5 clk = ~clk;

  sram_hw_ctrl #(.ADDR_W(AW), .DATA_W(DW), .RD_CYC(RD), .WR_CYC(WR), .TURN_CYC(TN)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_lanes(req_lanes),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_en1_n(mem_en1_n), .mem_en2(mem_en2),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_lo_n(mem_lo_n),
    .mem_hi_n(mem_hi_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // Memory as seen on the pins, and the reference contents
  logic [31:0] mmod [int unsigned];
  logic [31:0] refm [int unsigned];

  function automatic logic [31:0] mget(input int unsigned a);
    return mmod.exists(a) ? mmod[a] : 32'h0;
  endfunction
  function automatic logic [31:0] rget(input int unsigned a);
    return refm.exists(a) ? refm[a] : 32'h0;
  endfunction

  // Host-side reference: cycles left in the access, expected response
  int          rem = 0;
  bit          cur_wr = 0;
  logic [AW-1:0] cur_addr = '0;
  logic [1:0]  cur_lanes = 2'b00;
  bit          exp_rsp = 0;
  logic [31:0] exp_data = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      rem = 0;
      exp_rsp = 0;
    end else begin
      exp_rsp = 0;
      if (rem == 0) begin
        if (req_valid) begin
          cur_wr = req_write;
          cur_addr = req_addr;
          cur_lanes = req_lanes;
          if (req_write) begin
            logic [31:0] w;
            w = rget(req_addr);
            if (req_lanes[0]) w[15:0]  = req_wdata[15:0];
            if (req_lanes[1]) w[31:16] = req_wdata[31:16];
            refm[req_addr] = w;
            rem = TN + WR + 1;
          end else begin
            exp_data = rget(req_addr) & {{16{req_lanes[1]}}, {16{req_lanes[0]}}};
            rem = RD;
          end
        end
      end else begin
        rem--;
        if (rem == 0 && !cur_wr) exp_rsp = 1;
      end
    end
  end

  // Pin-level memory model and per-cycle comparison, half a period after each edge
  bit we_prev = 1;
  int we_low_cnt = 0;
  int drv_cnt = 0;

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic sel;
      logic [1:0] mdrv;
      sel = !mem_en1_n && mem_en2;
      mdrv[0] = sel && !mem_oe_n && mem_we_n && !mem_lo_n;
      mdrv[1] = sel && !mem_oe_n && mem_we_n && !mem_hi_n;

      // R10: never both sides on one lane
      check((mdrv & mem_dq_oe) == 2'b00, "R10 contention", {30'd0, mem_dq_oe}, {30'd0, ~mdrv});
      // R2: strobes only while selected, never together
      if (!mem_we_n || !mem_oe_n)
        check(sel && !(!mem_we_n && !mem_oe_n), "R2 strobe select", {30'd0, mem_we_n, mem_oe_n}, 32'd1);

      // R6/R3/R11: handshake timing from the reference
      check(req_ready == (rem == 0), "R6 R3 R11 ready", {31'd0, req_ready}, {31'd0, rem == 0});
      check(rsp_valid == exp_rsp, "R3 rsp_valid", {31'd0, rsp_valid}, {31'd0, exp_rsp});
      if (exp_rsp) check(rsp_rdata == exp_data, "R5 rdata", rsp_rdata, exp_data);

      if (rem == 0) begin
        check(mem_en1_n && !mem_en2 && mem_we_n && mem_oe_n && mem_dq_oe == 2'b00
              && mem_lo_n && mem_hi_n, "R1 R4 idle pins",
              {25'd0, mem_en1_n, mem_en2, mem_we_n, mem_oe_n, mem_lo_n, mem_hi_n, |mem_dq_oe},
              32'h5E);
      end else begin
        check(mem_addr == cur_addr, "R9 address held", {15'd0, mem_addr}, {15'd0, cur_addr});
        check({mem_hi_n, mem_lo_n} == ~cur_lanes, "R4 lane pins", {30'd0, mem_hi_n, mem_lo_n},
              {30'd0, ~cur_lanes});
        if (!cur_wr) check(mem_we_n, "R3 no write strobe in read", {31'd0, mem_we_n}, 32'd1);
        else         check(mem_oe_n, "R6 no output enable in write", {31'd0, mem_oe_n}, 32'd1);
      end

      // Write pulse shape and memory update on write enable rising
      if (!mem_we_n) begin
        we_low_cnt++;
        if (mem_dq_oe != 2'b00) drv_cnt++;
      end
      if (!we_prev && mem_we_n) begin
        check(we_low_cnt == TN + WR, "R6 write strobe length", we_low_cnt, TN + WR);
        check(drv_cnt == ((mem_lo_n && mem_hi_n) ? 0 : WR), "R7 data drive while strobe low",
              drv_cnt, (mem_lo_n && mem_hi_n) ? 0 : WR);
        check(sel, "R7 strobe rises while selected", {31'd0, sel}, 32'd1);
        if (sel) begin
          logic [31:0] w;
          w = mget(mem_addr);
          if (!mem_lo_n) begin
            check(mem_dq_oe[0], "R7 R8 low lane held", {30'd0, mem_dq_oe}, 32'd1);
            w[15:0] = mem_dq_out[15:0];
          end
          if (!mem_hi_n) begin
            check(mem_dq_oe[1], "R7 R8 high lane held", {30'd0, mem_dq_oe}, 32'd2);
            w[31:16] = mem_dq_out[31:16];
          end
          mmod[mem_addr] = w;
        end
        we_low_cnt = 0;
        drv_cnt = 0;
      end
      we_prev = mem_we_n;

      // Read side: only selected lanes carry data, the rest float (pattern)
      mem_dq_in[15:0]  = mdrv[0] ? mget(mem_addr) >> 0  : 16'hA5A5;
      mem_dq_in[31:16] = mdrv[1] ? mget(mem_addr) >> 16 : 16'hA5A5;
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT && !finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      finish_run();
    end
  end

  task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [1:0] ln, input logic [31:0] d);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_lanes = ln;
    req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    req_wdata = ~d;
    req_addr  = ~a;
  endtask

  task automatic drain();
    while (!req_ready) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    // R1: pins idle while held in reset and just after
    repeat (3) @(negedge clk);
    check(req_ready && mem_en1_n && !mem_en2 && mem_we_n && mem_oe_n && mem_dq_oe == 2'b00,
          "R1 reset state", {27'd0, req_ready, mem_en1_n, mem_en2, mem_we_n, mem_oe_n}, 32'h1B);
    rst_n = 1'b1;
    @(negedge clk);

    // Full-word writes including both address extremes (R6, R7)
    issue(1, 17'h00000, 2'b11, 32'h1111_2222);
    issue(1, 17'h1FFFF, 2'b11, 32'hDEAD_BEEF);
    issue(1, 17'h15555, 2'b11, 32'h0BAD_F00D);
    // Full reads (R3, R5)
    issue(0, 17'h00000, 2'b11, 32'h0);
    issue(0, 17'h1FFFF, 2'b11, 32'h0);
    issue(0, 17'h15555, 2'b11, 32'h0);
    // Half-word writes then full read-back (R4, R8)
    issue(1, 17'h1FFFF, 2'b10, 32'h1234_5678);
    issue(1, 17'h15555, 2'b01, 32'h9ABC_DEF0);
    issue(0, 17'h1FFFF, 2'b11, 32'h0);
    issue(0, 17'h15555, 2'b11, 32'h0);
    // Half-word reads and an empty-mask read return zero lanes (R5)
    issue(0, 17'h1FFFF, 2'b01, 32'h0);
    issue(0, 17'h1FFFF, 2'b10, 32'h0);
    issue(0, 17'h1FFFF, 2'b00, 32'h0);
    // Empty-mask write changes nothing (R8)
    issue(1, 17'h00000, 2'b00, 32'hFFFF_FFFF);
    issue(0, 17'h00000, 2'b11, 32'h0);
    // R11: request pulsed while busy must be ignored
    issue(1, 17'h0000A, 2'b11, 32'hCAFE_0001);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h0000A; req_lanes = 2'b11;
    req_wdata = 32'h0000_0000;
    @(negedge clk);
    req_valid = 1'b0;
    issue(0, 17'h0000A, 2'b11, 32'h0);
    drain();

    // Mixed traffic with back-to-back accesses
    begin
      logic [31:0] x;
      x = 32'h1357_9BDF;
      for (int i = 0; i < 400; i++) begin
        logic [AW-1:0] a;
        x = x * 32'd1103515245 + 32'd12345;
        a = AW'((x >> 8) & 32'h1F) ^ (x[25] ? 17'h1FFE0 : 17'h0);
        issue(x[20], a, x[22:21], x ^ 32'h5A5A_0F0F);
      end
    end
    drain();
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule